// File: doc/BRIEF.md
# Utilization-driven fabric frequency governor

This block chooses the clock ratio of a shared fabric domain. Once per evaluation interval the cores deliver an averaged utilization code, qualified by a one-cycle valid pulse. The block compares that code against a low and a high threshold held in a 64-bit control register. Light load drops the ratio to a configured floor. Heavy load, when the high-threshold path is enabled, raises the ratio by one unit (100 MHz) per interval. The climb halts while a power-limit flag is raised. The result is always held between the configured minimum and maximum ratio.

Software sets the control register through a plain write strobe with 64-bit data, and reads the stored value back on a combinational read bus. The ratio only moves on a sample pulse, so a new configuration first shows at the output at the next sample after the write.

Top module: `fabric_ratio_governor`

## Requirements
- R1: The control register keeps maximum ratio in bits 14:8, minimum ratio in bits 21:15, floor ratio in bits 28:22, low threshold in bits 38:32, high-threshold enable in bit 39 and high threshold in bits 46:40. Thresholds use a 7-bit scale where 127 is full load, so p percent is code p*127/100. A read returns these fields as written, and bits 7:0, 31:29 and 63:47 read as zero.
- R2: After reset the register reads zero and the ratio output is zero, which is the minimum ratio of the cleared register.
- R3: On a sample whose utilization code is strictly below the low threshold, the ratio becomes the floor ratio.
- R4: When the floor ratio is below the minimum ratio, a light-load sample sets the ratio to the minimum ratio instead.
- R5: On a sample with the enable bit at 1, a code strictly above the high threshold and power limit low, the ratio rises by exactly one unit.
- R6: While power limit is high, a heavy-load sample leaves an in-range ratio unchanged.
- R7: A sample that is neither light load nor enabled heavy load leaves an in-range ratio unchanged. This covers a code between the thresholds, or a code above the high threshold with the enable bit at 0.
- R8: After every sample the ratio is limited to at most the maximum ratio and then to at least the minimum ratio, so the minimum wins when it exceeds the maximum.
- R9: Without a sample pulse the ratio does not change. A write in the same cycle as a sample does not affect that sample's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_data | input | 64 | Write data for the control register |
| cfg_rd_data | output | 64 | Stored control register, unused bits zero |
| util_valid | input | 1 | One-cycle pulse marking an evaluation interval |
| util_code | input | 7 | Averaged utilization, 127 is full load |
| pwr_limit | input | 1 | Power limit reached, blocks upward steps |
| ratio | output | 7 | Current fabric ratio, one unit is 100 MHz |

## Verification
A register write and a utilization sample can arrive in the same cycle. The decision must then use the old configuration, and the new one takes effect only at the following sample. The bench issues writes and samples together in directed cases that change the floor, the limits and the enable. It also issues them together at random. A reference model applies the write after it evaluates the sample, and the output ratio is compared after each edge.

// File: rtl/gov_pkg.sv
// Package: shared widths, field positions and the decoded configuration
// type for the fabric ratio governor. Assumes a 64-bit control word.
package gov_pkg;
    localparam int RATIO_W = 7;
    localparam int UTIL_W  = 7;
    localparam int CFG_W   = 64;

    // Field positions are fixed: software and the decoder both rely on them.
    localparam int MAX_LSB   = 8;
    localparam int MIN_LSB   = 15;
    localparam int FLOOR_LSB = 22;
    localparam int LOW_LSB   = 32;
    localparam int HIEN_BIT  = 39;
    localparam int HIGH_LSB  = 40;

    localparam logic [CFG_W-1:0] CFG_MASK = 64'h0000_7FFF_1FFF_FF00;

    typedef struct packed {
        logic [RATIO_W-1:0] max_ratio;
        logic [RATIO_W-1:0] min_ratio;
        logic [RATIO_W-1:0] floor_ratio;
        logic [UTIL_W-1:0]  low_thr;
        logic               high_en;
        logic [UTIL_W-1:0]  high_thr;
    } gov_cfg_t;
endpackage

// File: rtl/gov_ctrl_reg.sv
// Module: control register. Stores the writable fields of a write, forces
// unused bits to zero, and decodes the fields for the decision logic.
// Assumes a full 64-bit write per strobe; reads are combinational.
module gov_ctrl_reg
    import gov_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output gov_cfg_t         cfg
);
    logic [CFG_W-1:0] store_q;

    // Capture the implemented bits of each write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (wr_en)
            store_q <= wr_data & CFG_MASK;
    end

    // Decode fields at their fixed positions.
    always_comb begin
        cfg.max_ratio   = store_q[MAX_LSB   +: RATIO_W];
        cfg.min_ratio   = store_q[MIN_LSB   +: RATIO_W];
        cfg.floor_ratio = store_q[FLOOR_LSB +: RATIO_W];
        cfg.low_thr     = store_q[LOW_LSB   +: UTIL_W];
        cfg.high_en     = store_q[HIEN_BIT];
        cfg.high_thr    = store_q[HIGH_LSB  +: UTIL_W];
    end

    assign rd_data = store_q;

    // R1: unused bits never read as one.
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~CFG_MASK) == '0);

    // R1: a write is readable unchanged in its implemented fields.
    p_write_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == ($past(wr_data) & CFG_MASK));
endmodule

// File: rtl/gov_decide.sv
// Module: combinational ratio decision. From the current ratio, the
// configuration, the utilization code and the power-limit flag it forms
// the ratio to load on a sample. Assumes the caller loads it only on a
// sample pulse.
module gov_decide
    import gov_pkg::*;
(
    input  gov_cfg_t           cfg,
    input  logic [RATIO_W-1:0] cur_ratio,
    input  logic [UTIL_W-1:0]  util,
    input  logic               pwr_limit,
    output logic [RATIO_W-1:0] next_ratio
);
    localparam int WIDE_W = RATIO_W + 1;

    logic [RATIO_W-1:0] floor_eff;
    logic [WIDE_W-1:0]  cand;
    logic [WIDE_W-1:0]  capped;
    logic               light, heavy;

    // Classify the load and pick the raw candidate before limiting.
    always_comb begin
        floor_eff = (cfg.floor_ratio < cfg.min_ratio) ? cfg.min_ratio : cfg.floor_ratio;
        light     = util < cfg.low_thr;
        heavy     = cfg.high_en && (util > cfg.high_thr);
        if (light)
            cand = {1'b0, floor_eff};
        else if (heavy && !pwr_limit)
            cand = {1'b0, cur_ratio} + WIDE_W'(1);
        else
            cand = {1'b0, cur_ratio};
    end

    // Limit to the maximum first, then to the minimum.
    always_comb begin
        capped = (cand > {1'b0, cfg.max_ratio}) ? {1'b0, cfg.max_ratio} : cand;
        if (capped < {1'b0, cfg.min_ratio})
            capped = {1'b0, cfg.min_ratio};
        next_ratio = capped[RATIO_W-1:0];
    end
endmodule

// File: rtl/fabric_ratio_governor.sv
// Module: top of the governor. Holds the current ratio and loads a new one
// from the decision logic on each utilization sample. Assumes util_valid is
// a single-cycle pulse per evaluation interval.
module fabric_ratio_governor
    import gov_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [CFG_W-1:0]   cfg_wr_data,
    output logic [CFG_W-1:0]   cfg_rd_data,
    input  logic               util_valid,
    input  logic [UTIL_W-1:0]  util_code,
    input  logic               pwr_limit,
    output logic [RATIO_W-1:0] ratio
);
    gov_cfg_t           cfg;
    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] ratio_d;

    gov_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    gov_decide u_decide (
        .cfg        (cfg),
        .cur_ratio  (ratio_q),
        .util       (util_code),
        .pwr_limit  (pwr_limit),
        .next_ratio (ratio_d)
    );

    // Current ratio: zero (the cleared minimum) on reset, reload per sample.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ratio_q <= '0;
        else if (util_valid)
            ratio_q <= ratio_d;
    end

    assign ratio = ratio_q;

    // R9: no sample, no movement.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !util_valid |=> $stable(ratio));

    // R8: after a sample the ratio lies within a consistent range.
    p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (util_valid && cfg.min_ratio <= cfg.max_ratio) |=>
        (ratio >= $past(cfg.min_ratio) && ratio <= $past(cfg.max_ratio)));

    // R5: a non-light sample from an in-range ratio climbs at most one unit.
    p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (util_valid && util_code >= cfg.low_thr && ratio >= cfg.min_ratio) |=>
        ({1'b0, ratio} <= {1'b0, $past(ratio)} + 8'd1));

    // R6: power limit freezes an in-range ratio on a non-light sample.
    p_pwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (util_valid && pwr_limit && util_code >= cfg.low_thr &&
         ratio >= cfg.min_ratio && ratio <= cfg.max_ratio) |=> $stable(ratio));

    // R3: light load lands on an in-range floor.
    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (util_valid && util_code < cfg.low_thr && cfg.floor_ratio >= cfg.min_ratio &&
         cfg.floor_ratio <= cfg.max_ratio) |=> ratio == $past(cfg.floor_ratio));
endmodule

// File: tb/fabric_ratio_governor_bench.sv
// Bench: directed corner cases plus seeded random traffic, compared with a
// reference model built from the requirements.
module fabric_ratio_governor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [63:0] cfg_wr_data = '0;
    logic [63:0] cfg_rd_data;
    logic        util_valid = 1'b0;
    logic [6:0]  util_code = '0;
    logic        pwr_limit = 1'b0;
    logic [6:0]  ratio;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_cfg = '0;
    logic [6:0]  m_ratio = '0;

    always #2.5 clk = ~clk;

    fabric_ratio_governor u_fabric_ratio_governor (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .util_valid(util_valid), .util_code(util_code),
        .pwr_limit(pwr_limit), .ratio(ratio)
    );

    function automatic logic [6:0] pct(input int p);
        return 7'(p * 127 / 100);
    endfunction

    function automatic logic [63:0] mk_cfg(input int mx, input int mn, input int fl,
                                           input int lo, input bit en, input int hi);
        logic [63:0] v = '0;
        v[14:8] = 7'(mx); v[21:15] = 7'(mn); v[28:22] = 7'(fl);
        v[38:32] = 7'(lo); v[39] = en; v[46:40] = 7'(hi);
        return v;
    endfunction

    // Reference decision from the requirements.
    function automatic logic [6:0] model_next(input logic [63:0] c, input logic [6:0] cur,
                                              input logic [6:0] u, input bit pl);
        int mx = int'(c[14:8]);
        int mn = int'(c[21:15]);
        int fl = int'(c[28:22]);
        int r;
        if (u < c[38:32])                       r = (fl < mn) ? mn : fl;
        else if (c[39] && u > c[46:40] && !pl)  r = int'(cur) + 1;
        else                                    r = int'(cur);
        if (r > mx) r = mx;
        if (r < mn) r = mn;
        return 7'(r);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check after the rising edge.
    task automatic cyc(input bit wr, input logic [63:0] wd, input bit sv,
                       input logic [6:0] u, input bit pl, input string req);
        @(negedge clk);
        cfg_wr_en = wr; cfg_wr_data = wd; util_valid = sv; util_code = u; pwr_limit = pl;
        @(posedge clk);
        #1;
        if (sv) m_ratio = model_next(m_cfg, m_ratio, u, pl);
        if (wr) m_cfg = wd & 64'h0000_7FFF_1FFF_FF00;
        check(req, {57'd0, ratio}, {57'd0, m_ratio});
        check("R1", cfg_rd_data, m_cfg);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R2", {57'd0, ratio}, 64'd0);
        check("R2", cfg_rd_data, 64'd0);

        // R1: all-ones write reads back only implemented bits.
        cyc(1, '1, 0, 0, 0, "R1");
        check("R1", cfg_rd_data, 64'h0000_7FFF_1FFF_FF00);
        // Working configuration: min 8, max 20, floor 12, 10%/95%, enabled.
        cyc(1, mk_cfg(20, 8, 12, pct(10), 1, pct(95)), 0, 0, 0, "R9");
        check("R1", {57'd0, cfg_rd_data[38:32]}, 64'd12);
        cyc(0, 0, 1, 5, 0, "R3");
        check("R3", {57'd0, ratio}, 64'd12);
        for (int i = 0; i < 10; i++) cyc(0, 0, 1, 125, 0, "R5");
        check("R8", {57'd0, ratio}, 64'd20);
        cyc(0, 0, 1, 5, 0, "R3");
        cyc(0, 0, 1, 125, 1, "R6");
        check("R6", {57'd0, ratio}, 64'd12);
        cyc(0, 0, 1, 60, 0, "R7");
        // Enable clear: heavy load holds.
        cyc(1, mk_cfg(20, 8, 12, pct(10), 0, pct(95)), 0, 0, 0, "R9");
        cyc(0, 0, 1, 126, 0, "R7");
        check("R7", {57'd0, ratio}, 64'd12);
        // Floor below minimum.
        cyc(1, mk_cfg(30, 16, 3, 20, 1, 100), 0, 0, 0, "R9");
        check("R9", {57'd0, ratio}, 64'd12);
        cyc(0, 0, 1, 4, 0, "R4");
        check("R4", {57'd0, ratio}, 64'd16);
        // Write and sample in the same cycle: old config decides.
        cyc(1, mk_cfg(40, 35, 38, 20, 1, 100), 1, 110, 0, "R9");
        check("R9", {57'd0, ratio}, 64'd17);
        cyc(0, 0, 1, 110, 0, "R8");
        check("R8", {57'd0, ratio}, 64'd35);
        // Minimum above maximum: minimum wins.
        cyc(1, mk_cfg(10, 25, 5, 20, 1, 100), 1, 4, 0, "R9");
        cyc(0, 0, 1, 4, 0, "R8");
        check("R8", {57'd0, ratio}, 64'd25);
        // Top of the ratio range.
        cyc(1, mk_cfg(127, 126, 126, 0, 1, 0), 1, 60, 0, "R8");
        cyc(0, 0, 1, 60, 0, "R5");
        cyc(0, 0, 1, 60, 0, "R8");
        check("R8", {57'd0, ratio}, 64'd127);

        // Random traffic.
        for (int i = 0; i < 2000; i++) begin
            bit wr = ($urandom % 8) == 0;
            logic [63:0] wd;
            int mn = $urandom % 40;
            if ($urandom % 4 == 0) wd = {$urandom, $urandom};
            else wd = mk_cfg(mn + $urandom % 50 - 5, mn, $urandom % 60,
                             $urandom % 50, $urandom % 2, 60 + $urandom % 67);
            cyc(wr, wd, $urandom % 2, 7'($urandom), ($urandom % 4) == 0, "R8");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule